// File: doc/BRIEF.md
# Multi-Bank Memory Window Controller

This controller sits between an 8-bit CPU and a set of five physical memory banks: a ROM bank, a user RAM bank, two video RAM banks and one extra bank. It splits the 64 KB CPU address space into eight 8 KB windows. For each window it decides which single bank drives read data, and for every CPU write it decides which banks capture the byte. Several banks may capture the same write in one cycle, but only one bank ever drives a read.

Two I/O-mapped registers set the mapping. The bank register holds four write-enable bits and four read-request bits. The control register holds two bits that block writes to the video banks. The mapping is a combinational function of both registers and of the current address. A change to either register therefore applies to the very next memory access, and a write to the control register alone reshapes the mapping from the stored bank register contents.

Top module: `bank_window_ctrl`

## Requirements
- R1: After reset both registers hold zero. A read in windows 0 to 2 (address 0x0000 to 0x5FFF) selects bank 0, a read in windows 3 to 7 selects bank 1, and a write enables bank 1 only (wr_en = 5'b00010).
- R2: An I/O write whose port has low seven bits equal to 0x7F loads io_data into the bank register, whatever the upper port bits are.
- R3: The bank register bits at positions 0, 4 and 5 are active-low. The effective value is the stored byte XOR 0x31.
- R4: Effective bank bits 0 to 3 enable writes to banks 1 to 4 respectively. A memory write raises wr_en for every enabled bank in the same cycle. wr_en[0] (ROM) is never raised.
- R5: An I/O write whose port has low eight bits equal to 0x80 loads the control register, whatever the upper byte is. Control bit 2 blocks writes to bank 2 and control bit 3 blocks writes to bank 3.
- R6: Effective bank bits 4 to 7 request reads from ROM, user RAM, video RAM and bank 4. The read comes from the lowest-numbered requested bank that serves the window. ROM serves only windows 0 to 2. Video RAM serves windows 0 to 3 from bank 2 and windows 4 to 7 from bank 3.
- R7: When no requested bank serves the window, the read falls back to bank 0 in windows 0 to 2 and to bank 1 in windows 3 to 7.
- R8: rd_sel is one-hot (bit n = bank n) while mem_rd is high and zero otherwise. wr_en is zero while mem_wr is low. rd_bank always gives the read bank of the current window.
- R9: A register write takes effect at the clock edge that captures it. The access in the next cycle already sees the new mapping. A control-register write alone recomputes the mapping from the stored bank register.
- R10: I/O writes to any other port, such as 0x017E or 0x0081, change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 16 | I/O port number |
| io_data | input | 8 | I/O write data |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| rd_sel | output | 5 | One-hot read select, bit n = bank n |
| rd_bank | output | 3 | Encoded read bank for the current window |
| wr_en | output | 5 | Per-bank write enables, bit n = bank n |

## Verification
The bench builds the block with its default parameters. These are 16 address bits, eight windows, a ROM span of three windows, a video split after four windows, a bank port match of 0x7F under mask 0x7F and a control port match of 0x80 under mask 0xFF. With these values the window boundaries at 0x6000 and 0x8000 are in reach, where the ROM coverage and the video half change. The mirror decode can be reached through ports such as 0xFF7F and 0x3480. Every priority combination of the four read requests can be reached in a single window.

// File: rtl/bank_win_pkg.sv
package bank_win_pkg;

  localparam int unsigned REG_W      = 8;
  localparam int unsigned NUM_BANKS  = 5;
  localparam int unsigned BANK_ID_W  = 3;
  localparam logic [REG_W-1:0] ACT_LOW_FLIP = 8'h31;
  localparam int unsigned INH_LO_BIT = 2;
  localparam int unsigned INH_HI_BIT = 3;

  typedef logic [BANK_ID_W-1:0] bank_id_t;

  localparam bank_id_t BK_ROM    = 3'd0;
  localparam bank_id_t BK_USER   = 3'd1;
  localparam bank_id_t BK_VID_LO = 3'd2;
  localparam bank_id_t BK_VID_HI = 3'd3;
  localparam bank_id_t BK_EXT    = 3'd4;

  // rd_req: [0] rom, [1] user, [2] video, [3] extra
  // wr_req: [n] enables bank n+1
  typedef struct packed {
    logic [3:0] rd_req;
    logic [3:0] wr_req;
  } bank_fields_t;

  function automatic bank_fields_t unpack_bank(input logic [REG_W-1:0] raw);
    logic [REG_W-1:0] eff;
    bank_fields_t f;
    eff = raw ^ ACT_LOW_FLIP;
    f.wr_req = eff[3:0];
    f.rd_req = eff[7:4];
    return f;
  endfunction

endpackage

// File: rtl/bwc_regs.sv
module bwc_regs
  import bank_win_pkg::*;
#(
  parameter int unsigned IO_W           = 16,
  parameter logic [15:0] BANK_PORT      = 16'h007F,
  parameter logic [15:0] BANK_PORT_MASK = 16'h007F,
  parameter logic [15:0] CTRL_PORT      = 16'h0080,
  parameter logic [15:0] CTRL_PORT_MASK = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic [IO_W-1:0]  io_port,
  input  logic [REG_W-1:0] io_data,
  output logic [REG_W-1:0] bank_raw,
  output logic [REG_W-1:0] ctrl_reg
);

  localparam logic [IO_W-1:0] BMASK = IO_W'(BANK_PORT_MASK);
  localparam logic [IO_W-1:0] BMATCH = IO_W'(BANK_PORT) & BMASK;
  localparam logic [IO_W-1:0] CMASK = IO_W'(CTRL_PORT_MASK);
  localparam logic [IO_W-1:0] CMATCH = IO_W'(CTRL_PORT) & CMASK;

  logic hit_bank;
  logic hit_ctrl;

  assign hit_bank = io_wr && ((io_port & BMASK) == BMATCH);
  assign hit_ctrl = io_wr && ((io_port & CMASK) == CMATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_raw <= '0;
      ctrl_reg <= '0;
    end else begin
      if (hit_bank) bank_raw <= io_data;
      if (hit_ctrl) ctrl_reg <= io_data;
    end
  end

endmodule

// File: rtl/bwc_write_mask.sv
module bwc_write_mask
  import bank_win_pkg::*;
(
  input  bank_fields_t         fields,
  input  logic [REG_W-1:0]     ctrl_reg,
  input  logic                 mem_wr,
  output logic [NUM_BANKS-1:0] wr_en
);

  assign wr_en[BK_ROM] = 1'b0;

  for (genvar b = 1; b < NUM_BANKS; b++) begin : g_bank
    logic inhibit;
    if (b == int'(BK_VID_LO)) begin : g_inh_lo
      assign inhibit = ctrl_reg[INH_LO_BIT];
    end else if (b == int'(BK_VID_HI)) begin : g_inh_hi
      assign inhibit = ctrl_reg[INH_HI_BIT];
    end else begin : g_no_inh
      assign inhibit = 1'b0;
    end
    assign wr_en[b] = mem_wr & fields.wr_req[b-1] & ~inhibit;
  end

endmodule

// File: rtl/bwc_read_map.sv
module bwc_read_map
  import bank_win_pkg::*;
#(
  parameter int unsigned WIN_COUNT   = 8,
  parameter int unsigned ROM_WINDOWS = 3,
  parameter int unsigned VID_SPLIT   = 4,
  localparam int unsigned WIN_W      = $clog2(WIN_COUNT)
) (
  input  logic [3:0]       rd_req,
  input  logic [WIN_W-1:0] win,
  output bank_id_t         src
);

  bank_id_t win_src [WIN_COUNT];

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    localparam bit       ROM_HERE = (w < ROM_WINDOWS);
    localparam bank_id_t VID_BANK = (w < VID_SPLIT) ? BK_VID_LO : BK_VID_HI;
    localparam bank_id_t DEF_BANK = ROM_HERE ? BK_ROM : BK_USER;

    always_comb begin
      if (ROM_HERE && rd_req[0])  win_src[w] = BK_ROM;
      else if (rd_req[1])         win_src[w] = BK_USER;
      else if (rd_req[2])         win_src[w] = VID_BANK;
      else if (rd_req[3])         win_src[w] = BK_EXT;
      else                        win_src[w] = DEF_BANK;
    end
  end

  assign src = win_src[win];

endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
  import bank_win_pkg::*;
#(
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned IO_W           = 16,
  parameter int unsigned WIN_COUNT      = 8,
  parameter int unsigned ROM_WINDOWS    = 3,
  parameter int unsigned VID_SPLIT      = 4,
  parameter logic [15:0] BANK_PORT      = 16'h007F,
  parameter logic [15:0] BANK_PORT_MASK = 16'h007F,
  parameter logic [15:0] CTRL_PORT      = 16'h0080,
  parameter logic [15:0] CTRL_PORT_MASK = 16'h00FF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_wr,
  input  logic [IO_W-1:0]      io_port,
  input  logic [7:0]           io_data,
  input  logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rd,
  input  logic                 mem_wr,
  output logic [4:0]           rd_sel,
  output logic [2:0]           rd_bank,
  output logic [4:0]           wr_en
);

  localparam int unsigned WIN_W = $clog2(WIN_COUNT);

  logic [REG_W-1:0] bank_raw;
  logic [REG_W-1:0] ctrl_reg;
  bank_fields_t     fields;
  logic [WIN_W-1:0] win;
  bank_id_t         src;

  bwc_regs #(
    .IO_W(IO_W), .BANK_PORT(BANK_PORT), .BANK_PORT_MASK(BANK_PORT_MASK),
    .CTRL_PORT(CTRL_PORT), .CTRL_PORT_MASK(CTRL_PORT_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .bank_raw(bank_raw), .ctrl_reg(ctrl_reg)
  );

  assign fields = unpack_bank(bank_raw);
  assign win    = mem_addr[ADDR_W-1 -: WIN_W];

  bwc_write_mask u_wmask (
    .fields(fields), .ctrl_reg(ctrl_reg), .mem_wr(mem_wr), .wr_en(wr_en)
  );

  bwc_read_map #(
    .WIN_COUNT(WIN_COUNT), .ROM_WINDOWS(ROM_WINDOWS), .VID_SPLIT(VID_SPLIT)
  ) u_rmap (
    .rd_req(fields.rd_req), .win(win), .src(src)
  );

  assign rd_bank = src;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rdsel
    assign rd_sel[b] = mem_rd && (src == bank_id_t'(b));
  end

endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned IO_W        = 16,
  parameter int unsigned WIN_COUNT   = 8,
  parameter int unsigned ROM_WINDOWS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic [IO_W-1:0]   io_port,
  input logic [7:0]        io_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [4:0]        rd_sel,
  input logic [2:0]        rd_bank,
  input logic [4:0]        wr_en
);

  localparam int unsigned WIN_W = $clog2(WIN_COUNT);
  logic [WIN_W-1:0] win;
  assign win = mem_addr[ADDR_W-1 -: WIN_W];

  assert_rd_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));

  assert_rd_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_rd |-> (rd_sel == 5'b0));

  assert_wr_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_wr |-> (wr_en == 5'b0));

  assert_rom_unwritten_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_en[0]);

  assert_rom_span_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && (int'(win) >= ROM_WINDOWS)) |-> !rd_sel[0]);

  assert_inhibit_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_port[7:0] == 8'h80) && io_data[2]) |=> !wr_en[2]);

  assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_port[6:0] == 7'h7F) && (io_data == 8'h31))
      |=> (wr_en == 5'b0));

  assert_reset_map_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst) && mem_wr) |-> (wr_en == 5'b00010));

endmodule

bind bank_window_ctrl bwc_checker #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .WIN_COUNT(WIN_COUNT), .ROM_WINDOWS(ROM_WINDOWS)
) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .rd_sel(rd_sel), .rd_bank(rd_bank), .wr_en(wr_en)
);

// File: tb/bank_window_ctrl_bench.sv
module bank_window_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [7:0]  io_data = '0;
  logic [15:0] mem_addr = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic [4:0]  rd_sel;
  logic [2:0]  rd_bank;
  logic [4:0]  wr_en;

  always #5 clk = ~clk;

  bank_window_ctrl u_bank_window_ctrl (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rd_sel(rd_sel), .rd_bank(rd_bank), .wr_en(wr_en)
  );

  typedef struct {
    logic [4:0] rd_sel;
    logic [2:0] rd_bank;
    logic [4:0] wr_en;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  logic [7:0] m_bank = 8'h00;
  logic [7:0] m_ctrl = 8'h00;

  // expected outputs from the requirements
  function automatic exp_t model(input logic [15:0] a, input bit rd, input bit wr,
                                 input string req);
    exp_t e;
    logic [7:0] eff;
    int win;
    int bk;
    logic [4:0] m;
    eff = m_bank ^ 8'h31;
    win = int'(a[15:13]);
    m = 5'b0;
    for (int b = 1; b < 5; b++) begin
      m[b] = eff[b-1];
    end
    if (m_ctrl[2]) m[2] = 1'b0;
    if (m_ctrl[3]) m[3] = 1'b0;
    if (eff[4] && win < 3)  bk = 0;
    else if (eff[5])        bk = 1;
    else if (eff[6])        bk = (win < 4) ? 2 : 3;
    else if (eff[7])        bk = 4;
    else                    bk = (win < 3) ? 0 : 1;
    e.rd_bank = 3'(bk);
    e.rd_sel  = rd ? (5'b1 << bk) : 5'b0;
    e.wr_en   = wr ? m : 5'b0;
    e.req     = req;
    return e;
  endfunction

  task automatic access(input logic [15:0] a, input bit rd, input bit wr, input string req);
    @(posedge clk); #1;
    io_wr = 1'b0; mem_addr = a; mem_rd = rd; mem_wr = wr;
    q.push_back(model(a, rd, wr, req));
  endtask

  task automatic io_write(input logic [15:0] p, input logic [7:0] d);
    @(posedge clk); #1;
    mem_rd = 1'b0; mem_wr = 1'b0;
    io_wr = 1'b1; io_port = p; io_data = d;
    if ((p & 16'h007F) == 16'h007F) m_bank = d;
    if ((p & 16'h00FF) == 16'h0080) m_ctrl = d;
  endtask

  // monitor: pops one expected item per cycle and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rd_sel !== e.rd_sel || rd_bank !== e.rd_bank || wr_en !== e.wr_en) begin
        failures++;
        $display("FAIL %s: rd_sel=%b rd_bank=%0d wr_en=%b expected rd_sel=%b rd_bank=%0d wr_en=%b",
                 e.req, rd_sel, rd_bank, wr_en, e.rd_sel, e.rd_bank, e.wr_en);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset mapping
    access(16'h0000, 1, 0, "R1");
    access(16'h6000, 1, 0, "R1");
    access(16'hE000, 1, 1, "R1");

    // R4 broadcast to all four, R6 video halves; R9 next-cycle effect
    io_write(16'h007F, 8'h7E);
    access(16'h2000, 1, 1, "R4");
    access(16'hA000, 1, 0, "R6");

    // R2 mirrored port, extra bank only
    io_write(16'hFF7F, 8'hB1);
    access(16'h0000, 1, 1, "R2");
    // R10 other port ignored
    io_write(16'h017E, 8'h00);
    access(16'h0000, 1, 1, "R10");

    // R3 active-low bits
    io_write(16'h807F, 8'h00);
    access(16'h4000, 1, 1, "R3");
    io_write(16'h007F, 8'hFF);
    access(16'h0000, 1, 1, "R3");

    // R5 inhibits, R9 recompute from stored register
    io_write(16'h0080, 8'h04);
    access(16'h8000, 1, 1, "R5");
    io_write(16'h3480, 8'h0C);
    access(16'h8000, 0, 1, "R9");
    io_write(16'h0081, 8'h00);
    access(16'h8000, 0, 1, "R10");
    io_write(16'h0080, 8'h00);
    access(16'h8000, 0, 1, "R5");

    // R6 priority
    io_write(16'h007F, 8'hC1);
    access(16'h2000, 1, 0, "R6");
    access(16'h6000, 1, 0, "R6");
    io_write(16'h007F, 8'hD1);
    access(16'h0000, 1, 0, "R6");
    io_write(16'h007F, 8'hF1);
    access(16'h6000, 1, 0, "R6");
    access(16'hE000, 1, 0, "R6");

    // R7 fallback
    io_write(16'h007F, 8'h31);
    access(16'h5FFF, 1, 0, "R7");
    access(16'h6000, 1, 1, "R7");
    io_write(16'h007F, 8'h21);
    access(16'hA000, 1, 0, "R7");
    access(16'h0000, 1, 0, "R7");

    // R8 strobes low
    io_write(16'h007F, 8'h7E);
    access(16'hC000, 0, 0, "R8");
    access(16'h2000, 0, 1, "R8");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule